// File: doc/BRIEF.md
# Quad Interleaved 8:1 Serializer

This block turns a 32-bit parallel word into four serial bit streams. It runs entirely on the fast bit clock. Each of the four lanes is an 8-bit shift register. Once per eight fast cycles, every lane takes its share of the word and then shifts it out one bit per fast cycle, lowest share first. The word is spread across the lanes in an interleaved way: lane k takes every fourth bit, starting at bit k.

A modulo-8 counter paces the loads and also produces a low-rate clock at one eighth of the fast rate, which the parallel source uses to present data. A two-bit phase select moves the load instant within the eight-cycle frame by 0, 2, 4 or 6 fast cycles. This lets the system pick how the parallel word lines up against the divided clock. The serial bits pass through one more fast-clock register before they leave the block, and the fast clock itself is forwarded beside them.

The phase select is meant to be static, or to change only while reset is held. A synchronous, active-high reset clears the counter and all lane registers.

Top module: `quad_lane_serializer`

## Requirements
- R1: Serial output `ser_out[k]` (k = 0..3) carries only the word bits `par_word[k + 4*i]` for i = 0..7.
- R2: Within a lane, bits go out in increasing index order. When the word is loaded at fast edge L, the bit with i = 0 is on `ser_out[k]` after edge L+1, and the bit with index i is on it after edge L+1+i.
- R3: `div_clk_out` has a period of eight fast cycles. It is high while the internal frame count (fast edges since reset release, modulo 8) is 0..3 and low while it is 4..7, so it is high for the first four cycles after reset release.
- R4: The parallel load happens at the fast edge where the frame count equals 2 × `phase_sel`, with `phase_sel` read as an unsigned value 0..3 (offsets 0, 2, 4, 6).
- R5: `par_word` is sampled only at the load edge. Its value at every other edge has no effect on `ser_out`.
- R6: Reset is synchronous and active high. After any edge with `rst` high, `ser_out` is all zero and `div_clk_out` is high. The frame count restarts at 0 on release.
- R7: Consecutive words stream without a gap. The last bit of one word (i = 7) is followed in the next cycle by the first bit of the next word.
- R8: `fast_clk_out` is the fast clock forwarded with the same level at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_sel | input | 2 | Load offset select: offset = 2 × value fast cycles |
| par_word | input | 32 | Parallel word, bit 0 sent first on lane 0 |
| ser_out | output | 4 | Registered serial bit per lane |
| fast_clk_out | output | 1 | Forwarded fast clock |
| div_clk_out | output | 1 | Fast clock divided by eight |

## Verification
Two things happen at the same fast edge: the parallel load of a new word and the shift that would otherwise move the previous word's last bit along the lane. The bench provokes this by driving words back to back, one in every frame, for each of the four phase settings. Between loads it puts random junk on the parallel input. A reference deserializer rebuilds each 32-bit word from the lanes and compares it with the word pushed by the driver, so a bit lost or repeated where the load and the shift meet shows up as a word mismatch. A reset raised on the very cycle of a load is also applied, and the bench checks that reset takes priority.

// File: rtl/qser_pkg.sv
package qser_pkg;
    localparam int unsigned QSER_LANES  = 4;
    localparam int unsigned QSER_RATIO  = 8;
    localparam int unsigned QSER_PSEL_W = 2;

    // Position of lane bit 'pos' of lane 'lane' in the parallel word
    function automatic int unsigned word_index(input int unsigned lane,
                                               input int unsigned pos,
                                               input int unsigned lanes);
        return pos * lanes + lane;
    endfunction
endpackage

// File: rtl/qser_divider.sv
module qser_divider #(
    parameter int unsigned RATIO  = qser_pkg::QSER_RATIO,
    parameter int unsigned PSEL_W = qser_pkg::QSER_PSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PSEL_W-1:0] phase_sel,
    output logic              load_o,
    output logic              div_clk_o
);
    localparam int unsigned CNT_W = $clog2(RATIO);
    localparam int unsigned STEP  = RATIO >> PSEL_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             div;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [CNT_W-1:0] offset;

    always_comb begin
        offset     = CNT_W'(phase_sel) * CNT_W'(STEP);
        st_d       = st_q;
        st_d.cnt   = st_q.cnt + 1'b1;
        st_d.div   = ~st_d.cnt[CNT_W-1];
        if (rst) begin
            st_d.cnt = '0;
            st_d.div = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign load_o    = (st_q.cnt == offset) && !rst;
    assign div_clk_o = st_q.div;
endmodule

// File: rtl/qser_lane.sv
module qser_lane #(
    parameter int unsigned RATIO = qser_pkg::QSER_RATIO
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [RATIO-1:0] bits_i,
    output logic             ser_o
);
    typedef struct packed {
        logic [RATIO-1:0] sreg;
        logic             ser;
    } lane_state_t;

    lane_state_t st_d, st_q;

    always_comb begin
        st_d.ser = st_q.sreg[0];
        if (load) begin
            st_d.sreg = bits_i;
        end else begin
            st_d.sreg = {1'b0, st_q.sreg[RATIO-1:1]};
        end
        if (rst) begin
            st_d.sreg = '0;
            st_d.ser  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ser_o = st_q.ser;
endmodule

// File: rtl/quad_lane_serializer.sv
module quad_lane_serializer
    import qser_pkg::*;
#(
    parameter int unsigned LANES  = QSER_LANES,
    parameter int unsigned RATIO  = QSER_RATIO,
    parameter int unsigned PSEL_W = QSER_PSEL_W
) (
    input  logic                   clk_fast,
    input  logic                   rst,
    input  logic [PSEL_W-1:0]      phase_sel,
    input  logic [LANES*RATIO-1:0] par_word,
    output logic [LANES-1:0]       ser_out,
    output logic                   fast_clk_out,
    output logic                   div_clk_out
);
    logic load;

    qser_divider #(.RATIO(RATIO), .PSEL_W(PSEL_W)) div_i (
        .clk       (clk_fast),
        .rst       (rst),
        .phase_sel (phase_sel),
        .load_o    (load),
        .div_clk_o (div_clk_out)
    );

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [RATIO-1:0] lane_bits;
        for (genvar p = 0; p < RATIO; p++) begin : g_bit
            assign lane_bits[p] = par_word[word_index(ln, p, LANES)];
        end
        qser_lane #(.RATIO(RATIO)) lane_i (
            .clk    (clk_fast),
            .rst    (rst),
            .load   (load),
            .bits_i (lane_bits),
            .ser_o  (ser_out[ln])
        );
    end

    assign fast_clk_out = clk_fast;
endmodule

// File: rtl/qser_checker.sv
module qser_checker #(
    parameter int unsigned LANES  = qser_pkg::QSER_LANES,
    parameter int unsigned RATIO  = qser_pkg::QSER_RATIO,
    parameter int unsigned PSEL_W = qser_pkg::QSER_PSEL_W
) (
    input logic                   clk,
    input logic                   rst,
    input logic [PSEL_W-1:0]      phase_sel,
    input logic [LANES*RATIO-1:0] par_word,
    input logic [LANES-1:0]       ser_out,
    input logic                   div_clk_out
);
    localparam int unsigned CNT_W = $clog2(RATIO);
    localparam int unsigned STEP  = RATIO >> PSEL_W;

    logic [CNT_W-1:0] frame_cnt;
    logic [CNT_W-1:0] exp_off;
    logic [LANES-1:0] first_b, last_b;
    logic             rst_q;

    always_ff @(posedge clk) begin
        if (rst) frame_cnt <= '0;
        else     frame_cnt <= frame_cnt + 1'b1;
        rst_q <= rst;
    end

    assign exp_off = CNT_W'(phase_sel) * CNT_W'(STEP);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_pick
        assign first_b[ln] = par_word[ln];
        assign last_b[ln]  = par_word[(RATIO-1)*LANES + ln];
    end

    // R6: outputs cleared after a reset edge
    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            assert_reset_clear_R6: assert (ser_out == '0 && div_clk_out == 1'b1)
                else $error("reset did not clear outputs");
        end
    end

    assert_div_level_R3: assert property (@(posedge clk) disable iff (rst)
        div_clk_out == ~frame_cnt[CNT_W-1]);

    assert_div_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(div_clk_out) |-> $past(div_clk_out, 4) == 1'b0);

    // R1, R2, R4: first lane bit appears two edges after the load edge
    assert_first_bit_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_cnt == exp_off) |-> ##2 (ser_out == $past(first_b, 2)));

    // R7: last lane bit appears nine edges after the load edge
    assert_last_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_cnt == exp_off) |-> ##9 (ser_out == $past(last_b, 9)));
endmodule

bind quad_lane_serializer qser_checker #(
    .LANES(LANES), .RATIO(RATIO), .PSEL_W(PSEL_W)
) chk_i (
    .clk         (clk_fast),
    .rst         (rst),
    .phase_sel   (phase_sel),
    .par_word    (par_word),
    .ser_out     (ser_out),
    .div_clk_out (div_clk_out)
);

// File: tb/quad_lane_serializer_tb_top.sv
module quad_lane_serializer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [31:0] w;
        int          ld;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  phase_sel = 2'd0;
    logic [31:0] par_word = '0;
    logic [3:0]  ser_out;
    logic        fast_clk_out;
    logic        div_clk_out;

    int   cyc = 0;
    logic rst_seen = 1'b1;
    int   n_chk = 0;
    int   n_bad = 0;
    exp_t sb_q[$];
    bit   collecting = 1'b0;
    int   pos = 0;
    logic [31:0] rx = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_lane_serializer dut_i (
        .clk_fast     (clk),
        .rst          (rst),
        .phase_sel    (phase_sel),
        .par_word     (par_word),
        .ser_out      (ser_out),
        .fast_clk_out (fast_clk_out),
        .div_clk_out  (div_clk_out)
    );

    always @(posedge clk) begin
        rst_seen <= rst;
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: reference deserializer and scoreboard compare
    always @(negedge clk) begin
        if (rst_seen) begin
            chk(ser_out == 4'b0, "R6 ser_out low in reset", 32'(ser_out), 32'h0);
            chk(div_clk_out == 1'b1, "R6 div clock high in reset", 32'(div_clk_out), 32'h1);
            sb_q.delete();
            collecting = 1'b0;
        end else begin
            chk(div_clk_out == ((cyc % 8) < 4), "R3 div clock level",
                32'(div_clk_out), 32'((cyc % 8) < 4));
            chk(fast_clk_out == 1'b0, "R8 forwarded clock low", 32'(fast_clk_out), 32'h0);
            if (!collecting && sb_q.size() > 0 && cyc == sb_q[0].ld + 2) begin
                collecting = 1'b1;
                pos = 0;
            end
            if (collecting) begin
                for (int k = 0; k < 4; k++) rx[k + 4*pos] = ser_out[k];
                pos++;
                if (pos == 8) begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(rx == e.w, "R1 R2 R4 R5 R7 word round trip", rx, e.w);
                    collecting = 1'b0;
                end
            end
        end
    end

    // Driver: present word just before the load edge, junk afterwards
    task automatic send_word(input logic [31:0] w);
        exp_t e;
        do @(negedge clk); while ((cyc % 8) != 2 * int'(phase_sel));
        par_word = w;
        e.w  = w;
        e.ld = cyc;
        sb_q.push_back(e);
        @(negedge clk);
        par_word = $urandom;
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst = 1'b1;
        repeat (n) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=finish", WATCHDOG);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(fast_clk_out == 1'b1, "R8 forwarded clock high", 32'(fast_clk_out), 32'h1);
        for (int ph = 0; ph < 4; ph++) begin
            phase_sel = 2'(ph);
            do_reset(3);
            send_word(32'h0000_0000);
            send_word(32'hFFFF_FFFF);
            send_word(32'h0000_000F);
            send_word(32'hF000_0000);
            send_word(32'hA5A5_5A5A);
            send_word(32'h1248_8421);
            for (int i = 0; i < 4; i++) send_word(32'h1 << (i * 9));
            for (int i = 0; i < 4; i++) send_word($urandom);
            repeat (12) @(negedge clk);
            chk(sb_q.size() == 0, "R7 all words delivered", 32'(sb_q.size()), 32'h0);
            // R6: reset raised on the load cycle wins over the load
            do @(negedge clk); while ((cyc % 8) != 2 * ph);
            par_word = 32'hFFFF_FFFF;
            rst = 1'b1;
            repeat (3) @(negedge clk);
            rst = 1'b0;
            send_word(32'h8001_7FFE);
            send_word(32'h0F0F_F0F0);
            repeat (12) @(negedge clk);
            chk(sb_q.size() == 0, "R6 words after reset delivered", 32'(sb_q.size()), 32'h0);
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule